// File: doc/BRIEF.md
# Exclusive Cache Eviction Router

This block sits between a private second-level cache and an exclusive last-level cache. It decides what happens to each line that the second-level cache evicts. It looks at four facts: whether the line is predicted live, whether it is dirty, whether it belongs to the repeatedly-reused class (the "hot" class), and whether the target last-level set still has a free way. From these it picks exactly one action. The line is allocated in the last-level cache, written back to the memory controller, or dropped so that it never reaches the interconnect.

A separate hit descriptor reports last-level lookups. On a hit, the router says whether the line must be de-allocated, as exclusivity requires, or kept. When the keep-hot mode is on, hot lines are held in non-inclusive fashion so they do not bounce back and forth. On a miss, the memory fill is routed straight to the second-level cache and never to the last-level cache. Three saturating event counters report how many evictions took each action, so the fractions of bypassed and written-back evictions can be measured.

Top module: `evroute_top`

## Requirements
- R1: A live eviction is allocated (action code 3'b001; bit 0 = allocate, bit 1 = write back, bit 2 = drop). This holds whenever keep-hot mode is off, or the line is not hot.
- R2: A dead eviction whose target set has a free way is allocated (3'b001).
- R3: A dead dirty eviction with no free way is written back to the memory controller (3'b010).
- R4: A dead clean eviction with no free way is dropped (3'b100).
- R5: With keep-hot mode on, a live hot eviction is allocated only if dirty. A live hot clean eviction is dropped (3'b100), even when a free way exists.
- R6: On a last-level hit, deallocOnHit is 0 only when keep-hot mode is on and the hit line is hot. It is 1 otherwise.
- R7: On a last-level miss, fillToL2 is 1 and deallocOnHit is 0. The fill never targets the last-level cache.
- R8: The action is registered: it appears one cycle after the eviction strobe, with actValid high and exactly one action bit set. With no eviction, actValid is 0 and all action bits are 0.
- R9: allocCount, wbCount and dropCount each rise by one per eviction taking that action. Each saturates at its all-ones maximum.
- R10: Reset clears every output, including the three counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keepHotMode | input | 1 | Enables non-inclusive handling of hot lines |
| evValid | input | 1 | Eviction descriptor valid |
| evLive | input | 1 | Line predicted live |
| evDirty | input | 1 | Line is dirty |
| evHot | input | 1 | Line is in the repeatedly-reused class |
| evFreeWay | input | 1 | Target last-level set has a free way |
| hitValid | input | 1 | Lookup descriptor valid |
| hitIsHit | input | 1 | 1 = last-level hit, 0 = miss |
| hitHot | input | 1 | Looked-up line is in the hot class |
| actValid | output | 1 | Action output valid |
| actOneHot | output | 3 | One-hot action: bit0 allocate, bit1 write back, bit2 drop |
| respValid | output | 1 | Lookup response valid |
| deallocOnHit | output | 1 | Hit line must be de-allocated |
| fillToL2 | output | 1 | Miss fill goes straight to the second-level cache |
| allocCount | output | CNT_W | Allocate events, saturating |
| wbCount | output | CNT_W | Write-back events, saturating |
| dropCount | output | CNT_W | Drop events, saturating |

## Verification
Every result is due exactly one clock edge after its descriptor:
- the action bits and respValid, deallocOnHit and fillToL2 settle on the first rising edge after the inputs are presented;
- a counter reflects an eviction at that same edge.

The bench drives each stimulus on a falling edge and samples on the very next falling edge, which lies after that single register stage. It then drops the valid strobes. One further falling edge later it checks that the outputs have returned to idle. This way a stale or early result cannot pass.

// File: rtl/evroute_pkg.sv
package evroute_pkg;
  localparam int NUM_ACT = 3;

  typedef enum logic [1:0] {
    ACT_ALLOC = 2'd0,
    ACT_WB    = 2'd1,
    ACT_DROP  = 2'd2
  } actIdx_e;

  typedef struct packed {
    logic               evStb;
    logic [NUM_ACT-1:0] actSel;
    logic               hitStb;
    logic               dealloc;
    logic               fillStb;
  } ctrlStb_t;
endpackage

// File: rtl/evroute_ctrl.sv
module evroute_ctrl
  import evroute_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     keepHotMode,
  input  logic     evValid,
  input  logic     evLive,
  input  logic     evDirty,
  input  logic     evHot,
  input  logic     evFreeWay,
  input  logic     hitValid,
  input  logic     hitIsHit,
  input  logic     hitHot,
  output ctrlStb_t stb
);
  logic hotHeld;
  logic sendLive;
  logic [NUM_ACT-1:0] sel;

  assign hotHeld = keepHotMode & evHot;

  always_comb begin
    sel = '0;
    sendLive = 1'b0;
    if (evValid) begin
      if (evLive) begin
        sendLive = hotHeld ? evDirty : 1'b1;
        if (sendLive) sel[ACT_ALLOC] = 1'b1;
        else          sel[ACT_DROP]  = 1'b1;
      end else if (evFreeWay) begin
        sel[ACT_ALLOC] = 1'b1;
      end else if (evDirty) begin
        sel[ACT_WB] = 1'b1;
      end else begin
        sel[ACT_DROP] = 1'b1;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.evStb   = evValid;
    stb.actSel  = sel;
    stb.hitStb  = hitValid;
    stb.dealloc = hitValid & hitIsHit & ~(keepHotMode & hitHot);
    stb.fillStb = hitValid & ~hitIsHit;
  end

  // R8
  sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evValid |-> $countones(stb.actSel) == 1);

  // R8
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evValid |-> stb.actSel == '0);

  // R4
  dead_clean_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evValid && !evLive && !evFreeWay && !evDirty) |-> stb.actSel[ACT_DROP]);

  // R7
  miss_no_dealloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hitValid && !hitIsHit) |-> (stb.fillStb && !stb.dealloc));
endmodule

// File: rtl/evroute_dp.sv
module evroute_dp
  import evroute_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStb_t           stb,
  output logic               actValid,
  output logic [NUM_ACT-1:0] actOneHot,
  output logic               respValid,
  output logic               deallocOnHit,
  output logic               fillToL2,
  output logic [CNT_W-1:0]   cntVec [NUM_ACT]
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actValid     <= 1'b0;
      actOneHot    <= '0;
      respValid    <= 1'b0;
      deallocOnHit <= 1'b0;
      fillToL2     <= 1'b0;
    end else begin
      actValid     <= stb.evStb;
      actOneHot    <= stb.evStb ? stb.actSel : '0;
      respValid    <= stb.hitStb;
      deallocOnHit <= stb.dealloc;
      fillToL2     <= stb.fillStb;
    end
  end

  for (genvar i = 0; i < NUM_ACT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cntVec[i] <= '0;
      else if (stb.evStb && stb.actSel[i] && cntVec[i] != CNT_MAX)
        cntVec[i] <= cntVec[i] + CNT_ONE;
    end

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.evStb && stb.actSel[i] && cntVec[i] != CNT_MAX)
        |=> cntVec[i] == $past(cntVec[i]) + CNT_ONE);

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb.evStb && stb.actSel[i]) |=> $stable(cntVec[i]));
  end

  // R8
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    actValid |-> $countones(actOneHot) == 1);

  // R8
  act_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.evStb |=> actValid);

  // R7
  resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> !(deallocOnHit && fillToL2));
endmodule

// File: rtl/evroute_top.sv
module evroute_top
  import evroute_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keepHotMode,
  input  logic             evValid,
  input  logic             evLive,
  input  logic             evDirty,
  input  logic             evHot,
  input  logic             evFreeWay,
  input  logic             hitValid,
  input  logic             hitIsHit,
  input  logic             hitHot,
  output logic             actValid,
  output logic [2:0]       actOneHot,
  output logic             respValid,
  output logic             deallocOnHit,
  output logic             fillToL2,
  output logic [CNT_W-1:0] allocCount,
  output logic [CNT_W-1:0] wbCount,
  output logic [CNT_W-1:0] dropCount
);
  ctrlStb_t         stb;
  logic [CNT_W-1:0] cntVec [NUM_ACT];

  evroute_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .keepHotMode (keepHotMode),
    .evValid     (evValid),
    .evLive      (evLive),
    .evDirty     (evDirty),
    .evHot       (evHot),
    .evFreeWay   (evFreeWay),
    .hitValid    (hitValid),
    .hitIsHit    (hitIsHit),
    .hitHot      (hitHot),
    .stb         (stb)
  );

  evroute_dp #(.CNT_W(CNT_W)) i_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .actValid     (actValid),
    .actOneHot    (actOneHot),
    .respValid    (respValid),
    .deallocOnHit (deallocOnHit),
    .fillToL2     (fillToL2),
    .cntVec       (cntVec)
  );

  assign allocCount = cntVec[ACT_ALLOC];
  assign wbCount    = cntVec[ACT_WB];
  assign dropCount  = cntVec[ACT_DROP];
endmodule

// File: tb/test_evroute_top.sv
`timescale 1ns/1ps
module test_evroute_top;
  localparam int CNT_W = 4;
  localparam int NVEC  = 15;
  // {mode, live, dirty, hot, free, expected action[2:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    {5'b01000, 3'b001}, // R1 live clean cold
    {5'b01110, 3'b001}, // R1 live dirty hot, mode off
    {5'b01010, 3'b001}, // R1 live clean hot, mode off
    {5'b00001, 3'b001}, // R2 dead clean free
    {5'b00101, 3'b001}, // R2 dead dirty free
    {5'b00100, 3'b010}, // R3 dead dirty no free
    {5'b00000, 3'b100}, // R4 dead clean no free
    {5'b00010, 3'b100}, // R4 dead clean hot no free
    {5'b11000, 3'b001}, // R1 mode on, live cold
    {5'b11110, 3'b001}, // R5 live hot dirty
    {5'b11010, 3'b100}, // R5 live hot clean
    {5'b11011, 3'b100}, // R5 live hot clean, free way
    {5'b10110, 3'b010}, // R3 mode on, dead dirty hot
    {5'b10001, 3'b001}, // R2 mode on, dead clean free
    {5'b10000, 3'b100}  // R4 mode on, dead clean no free
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic keepHotMode = 1'b0;
  logic evValid = 1'b0, evLive = 1'b0, evDirty = 1'b0, evHot = 1'b0, evFreeWay = 1'b0;
  logic hitValid = 1'b0, hitIsHit = 1'b0, hitHot = 1'b0;
  logic actValid, respValid, deallocOnHit, fillToL2;
  logic [2:0] actOneHot;
  logic [CNT_W-1:0] allocCount, wbCount, dropCount;

  int checks = 0;
  int fails = 0;
  int expA = 0, expW = 0, expD = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evroute_top #(.CNT_W(CNT_W)) i_evroute_top (
    .clk(clk), .rst_n(rst_n), .keepHotMode(keepHotMode),
    .evValid(evValid), .evLive(evLive), .evDirty(evDirty), .evHot(evHot),
    .evFreeWay(evFreeWay), .hitValid(hitValid), .hitIsHit(hitIsHit), .hitHot(hitHot),
    .actValid(actValid), .actOneHot(actOneHot), .respValid(respValid),
    .deallocOnHit(deallocOnHit), .fillToL2(fillToL2),
    .allocCount(allocCount), .wbCount(wbCount), .dropCount(dropCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  task automatic evict(input logic [4:0] d, input logic [2:0] exp, input string req);
    {keepHotMode, evLive, evDirty, evHot, evFreeWay} = d;
    evValid = 1'b1;
    @(negedge clk);
    chk(req, int'(actOneHot), int'(exp));
    chk("R8 actValid", int'(actValid), 1);
    evValid = 1'b0;
    if (exp[0]) expA++;
    if (exp[1]) expW++;
    if (exp[2]) expD++;
  endtask

  task automatic lookup(input logic mode, input logic isHit, input logic hot,
                        input int expDealloc, input int expFill, input string req);
    keepHotMode = mode; hitIsHit = isHit; hitHot = hot; hitValid = 1'b1;
    @(negedge clk);
    chk(req, int'(deallocOnHit), expDealloc);
    chk(req, int'(fillToL2), expFill);
    chk(req, int'(respValid), 1);
    hitValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    evValid = 1'b1; evLive = 1'b1; hitValid = 1'b1; hitIsHit = 1'b1;
    repeat (3) @(negedge clk);
    // R10 outputs held clear while reset is low, even with strobes up
    chk("R10 actValid", int'(actValid), 0);
    chk("R10 respValid", int'(respValid), 0);
    chk("R10 deallocOnHit", int'(deallocOnHit), 0);
    chk("R10 allocCount", int'(allocCount), 0);
    evValid = 1'b0; hitValid = 1'b0; evLive = 1'b0; hitIsHit = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      evict(VEC[i][7:3], VEC[i][2:0], $sformatf("R1-5 action vec%0d", i));
      @(negedge clk);
      // R8 idle after strobe removed
      chk("R8 idle valid", int'(actValid), 0);
      chk("R8 idle bits", int'(actOneHot), 0);
    end

    // R9 counters after table
    chk("R9 allocCount", int'(allocCount), sat(expA));
    chk("R9 wbCount", int'(wbCount), sat(expW));
    chk("R9 dropCount", int'(dropCount), sat(expD));

    // back-to-back evictions, then saturation of the allocate counter
    for (int i = 0; i < 10; i++) evict(5'b01000, 3'b001, "R1 back-to-back");
    evValid = 1'b0;
    @(negedge clk);
    chk("R9 allocCount saturated", int'(allocCount), sat(expA));
    chk("R9 wbCount unchanged", int'(wbCount), sat(expW));

    // R6 hit handling
    lookup(1'b1, 1'b1, 1'b1, 0, 0, "R6 hot hit kept");
    lookup(1'b1, 1'b1, 1'b0, 1, 0, "R6 cold hit dealloc");
    lookup(1'b0, 1'b1, 1'b1, 1, 0, "R6 hot hit mode off dealloc");
    // R7 miss fill
    lookup(1'b1, 1'b0, 1'b1, 0, 1, "R7 miss fill");
    lookup(1'b0, 1'b0, 1'b0, 0, 1, "R7 miss fill mode off");
    @(negedge clk);
    chk("R7 idle fill", int'(fillToL2), 0);

    // R10 reset mid-run clears counters
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 allocCount", int'(allocCount), 0);
    chk("R10 dropCount", int'(dropCount), 0);
    chk("R10 wbCount", int'(wbCount), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule